// File: doc/BRIEF.md
# Three-Phase PWM Input Decoder with Dead Time

This block sits between a motor controller's PWM outputs and the three half-bridge gate stages of a three-phase inverter. It accepts six logic-level control inputs, a high and a low input for each of phases A, B and C, and turns them into six registered gate commands. A 2-bit mode field selects how the inputs are read. In six-input mode each input drives one gate. In three-input mode each phase has one input that picks its high or its low switch. In single-input mode one pin carries the PWM signal and a 4-bit code on four other pins picks one of a set of block-commutation states.

Every phase has a dead-band stage. A gate always turns off on the next clock edge. A gate turns on only after its partner in the same phase has been off for the programmed dead time, so the two switches of a phase are never on together. The dead time comes from a 3-bit code and is converted into clock cycles from the clock period parameter. A disable input forces all six gates off and restarts the dead-time counting.

In single-input mode a freewheel option picks the behaviour of the low gate in each PWM-driven phase. With active freewheeling the low gate takes the inverted PWM signal. With diode freewheeling the low gate stays off.

Top module: `tpd_gate_decoder`

## Requirements
- R1: With in_mode 00 or 11 (six-input), each phase gives: high input alone = high gate on; low input alone = low gate on; both inputs set or both clear = both gates off.
- R2: With in_mode 01 (three-input), a phase's high input at 1 selects its high gate and at 0 selects its low gate. The low inputs have no effect.
- R3: With in_mode 10 (single-input), in_hi[0] carries PWM. In each PWM-driven phase the high gate follows PWM. The low gate follows inverted PWM when fw_diode=0 and stays off when fw_diode=1. in_lo[2] has no effect.
- R4: In single-input mode the code is {in_lo[0], in_hi[1], in_lo[1], in_hi[2]} (MSB first). The table lists the PWM phases and the low-on phases. 0110: A PWM / B low. 0101: A,C PWM / B low. 0100: C PWM / B low. 1101: C PWM / A,B low. 1100: C PWM / A low. 1001: B,C PWM / A low. 1000: B PWM / A low. 1011: B PWM / A,C low. 1010: B PWM / C low. 0011: A,B PWM / C low. 0010: A PWM / C low. 0111 and 1110: A PWM / B,C low.
- R5: Single-input codes 0000, 0001 and 1111 turn all six gates off.
- R6: dt_code maps to 40, 60, 100, 500, 1000, 2000, 4000 and 6000 ns for codes 0 to 7. At a 5 ns clock this is 8, 12, 20, 100, 200, 400, 800 and 1200 cycles. When a phase's request swaps from one gate to the other, the gate being released turns off at the first edge. The other gate turns on exactly that many edges later.
- R7: A gate turns off at the first clock edge after its request drops. A gate whose partner has been off for at least the dead time turns on at the first clock edge after its request rises.
- R8: The high and low gates of one phase are never on in the same cycle.
- R9: gate_off=1 forces all gates off at the next edge. After release, a requested gate turns on at the dead-time-th edge (dead time in cycles) after the first edge with gate_off=0.
- R10: After reset all six gates are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_hi | input | 3 | High-side control inputs, bit 0 = phase A |
| in_lo | input | 3 | Low-side control inputs, bit 0 = phase A |
| in_mode | input | 2 | Input mode: 00/11 six-input, 01 three-input, 10 single-input |
| fw_diode | input | 1 | Single-input mode: 1 = diode freewheel (low gate off), 0 = active freewheel |
| dt_code | input | 3 | Dead-time selection |
| gate_off | input | 1 | Forces all gates off and restarts dead-time counting |
| gate_hi | output | 3 | High-side gate commands, bit 0 = phase A |
| gate_lo | output | 3 | Low-side gate commands, bit 0 = phase A |

## Verification
Six-input mode is driven with all four input combinations under both mode codes, which exposes a wrong both-asserted rule or a missing mode alias. Three-input mode is run with the low inputs scrambled, and single-input mode walks every commutation code with PWM high. Single-input mode is also run with PWM low under both freewheel settings, which separates the PWM phases from the low-on phases and shows the freewheel choice. Dead-time gaps are counted edge by edge for several codes, including the longest, and these counts are set against the immediate turn-off, the one-edge turn-on after a long idle, and the recount after a disable.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

   typedef enum logic [1:0] {
      MODE_SIX_A  = 2'b00,
      MODE_THREE  = 2'b01,
      MODE_SINGLE = 2'b10,
      MODE_SIX_B  = 2'b11
   } in_mode_e;

   localparam int unsigned DT_NS_LONGEST = 6000;

   // dead time in nanoseconds for each selection code
   function automatic int unsigned dt_ns(input logic [2:0] code);
      int unsigned ns;
      case (code)
         3'd0:    ns = 40;
         3'd1:    ns = 60;
         3'd2:    ns = 100;
         3'd3:    ns = 500;
         3'd4:    ns = 1000;
         3'd5:    ns = 2000;
         3'd6:    ns = 4000;
         default: ns = DT_NS_LONGEST;
      endcase
      return ns;
   endfunction

   // rounds up so the gap is never shorter than asked
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
      return (ns + per - 1) / per;
   endfunction

   // returns {pwm_phases[2:0], low_on_phases[2:0]}, bit 0 = phase A
   function automatic logic [5:0] comm_decode(input logic [3:0] code);
      logic [5:0] r;
      case (code)
         4'b0110:          r = {3'b001, 3'b010};
         4'b0101:          r = {3'b101, 3'b010};
         4'b0100:          r = {3'b100, 3'b010};
         4'b1101:          r = {3'b100, 3'b011};
         4'b1100:          r = {3'b100, 3'b001};
         4'b1001:          r = {3'b110, 3'b001};
         4'b1000:          r = {3'b010, 3'b001};
         4'b1011:          r = {3'b010, 3'b101};
         4'b1010:          r = {3'b010, 3'b100};
         4'b0011:          r = {3'b011, 3'b100};
         4'b0010:          r = {3'b001, 3'b100};
         4'b0111, 4'b1110: r = {3'b001, 3'b110};
         default:          r = 6'b000000;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/tpd_input_decode.sv
module tpd_input_decode
   import tpd_pkg::*;
#(
   parameter int unsigned NUM_PHASES = 3
) (
   input  logic [NUM_PHASES-1:0] in_hi,
   input  logic [NUM_PHASES-1:0] in_lo,
   input  logic [1:0]            in_mode,
   input  logic                  fw_diode,
   output logic [NUM_PHASES-1:0] req_hi,
   output logic [NUM_PHASES-1:0] req_lo
);

   logic [5:0] sel;
   logic       pwm;

   always_comb begin
      sel = comm_decode({in_lo[0], in_hi[1], in_lo[1], in_hi[2]});
      pwm = in_hi[0];
      req_hi = '0;
      req_lo = '0;
      case (in_mode_e'(in_mode))
         MODE_THREE: begin
            req_hi = in_hi;
            req_lo = ~in_hi;
         end
         MODE_SINGLE: begin
            for (int i = 0; i < NUM_PHASES; i++) begin
               req_hi[i] = sel[3+i] & pwm;
               req_lo[i] = sel[i] | (sel[3+i] & ~pwm & ~fw_diode);
            end
         end
         default: begin
            req_hi = in_hi & ~in_lo;
            req_lo = in_lo & ~in_hi;
         end
      endcase
   end

endmodule

// File: rtl/tpd_deadband.sv
module tpd_deadband #(
   parameter int unsigned CW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          kill,
   input  logic [CW-1:0] dt_lim,
   input  logic          hi_req,
   input  logic          lo_req,
   output logic          g_hi,
   output logic          g_lo
);

   logic [CW-1:0] hi_off_cnt;
   logic [CW-1:0] lo_off_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         g_hi       <= 1'b0;
         g_lo       <= 1'b0;
         hi_off_cnt <= '0;
         lo_off_cnt <= '0;
      end else if (kill) begin
         g_hi       <= 1'b0;
         g_lo       <= 1'b0;
         hi_off_cnt <= '0;
         lo_off_cnt <= '0;
      end else begin
         g_hi <= hi_req & ~g_lo & (lo_off_cnt >= dt_lim);
         g_lo <= lo_req & ~g_hi & (hi_off_cnt >= dt_lim);
         if (g_hi)               hi_off_cnt <= '0;
         else if (~&hi_off_cnt)  hi_off_cnt <= hi_off_cnt + 1'b1;
         if (g_lo)               lo_off_cnt <= '0;
         else if (~&lo_off_cnt)  lo_off_cnt <= lo_off_cnt + 1'b1;
      end
   end

   // R1
   excl_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_req && lo_req));

   // R8
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(g_hi && g_lo));

   // R7
   off_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_req |=> !g_hi);

   // R9
   kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (!g_hi && !g_lo));

   // R6
   gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(g_hi) |-> !$past(g_lo));

endmodule

// File: rtl/tpd_gate_decoder.sv
module tpd_gate_decoder
   import tpd_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_NS = 5,
   parameter int unsigned NUM_PHASES    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PHASES-1:0] in_hi,
   input  logic [NUM_PHASES-1:0] in_lo,
   input  logic [1:0]            in_mode,
   input  logic                  fw_diode,
   input  logic [2:0]            dt_code,
   input  logic                  gate_off,
   output logic [NUM_PHASES-1:0] gate_hi,
   output logic [NUM_PHASES-1:0] gate_lo
);

   localparam int unsigned MAX_CYC = (DT_NS_LONGEST + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
   localparam int unsigned CW      = $clog2(MAX_CYC + 1);

   if (CLK_PERIOD_NS < 1 || CLK_PERIOD_NS > 40) begin : g_bad_period
      $error("CLK_PERIOD_NS must lie in 1..40");
   end
   if (NUM_PHASES != 3) begin : g_bad_phases
      $error("NUM_PHASES must be 3");
   end

   logic [NUM_PHASES-1:0] req_hi;
   logic [NUM_PHASES-1:0] req_lo;
   logic [CW-1:0]         dt_lim;

   always_comb dt_lim = CW'(ns_to_cyc(dt_ns(dt_code), CLK_PERIOD_NS) - 1);

   tpd_input_decode #(.NUM_PHASES(NUM_PHASES)) u_dec (
      .in_hi    (in_hi),
      .in_lo    (in_lo),
      .in_mode  (in_mode),
      .fw_diode (fw_diode),
      .req_hi   (req_hi),
      .req_lo   (req_lo)
   );

   for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
      tpd_deadband #(.CW(CW)) u_db (
         .clk    (clk),
         .rst_n  (rst_n),
         .kill   (gate_off),
         .dt_lim (dt_lim),
         .hi_req (req_hi[p]),
         .lo_req (req_lo[p]),
         .g_hi   (gate_hi[p]),
         .g_lo   (gate_lo[p])
      );
   end

endmodule

// File: tb/sim_tpd_gate_decoder.sv
`timescale 1ns/1ps
module sim_tpd_gate_decoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] in_hi = '0;
   logic [2:0] in_lo = '0;
   logic [1:0] in_mode = 2'b00;
   logic       fw_diode = 1'b0;
   logic [2:0] dt_code = 3'd0;
   logic       gate_off = 1'b0;
   logic [2:0] gate_hi;
   logic [2:0] gate_lo;

   int tests = 0;
   int fails = 0;

   localparam int unsigned DT_CYC [8] = '{8, 12, 20, 100, 200, 400, 800, 1200};
   localparam logic [3:0]  CODES  [13] = '{4'b0110, 4'b0101, 4'b0100, 4'b1101, 4'b1100,
      4'b1001, 4'b1000, 4'b1011, 4'b1010, 4'b0011, 4'b0010, 4'b0111, 4'b1110};
   localparam logic [2:0]  EXP_PWM [13] = '{3'b001, 3'b101, 3'b100, 3'b100, 3'b100,
      3'b110, 3'b010, 3'b010, 3'b010, 3'b011, 3'b001, 3'b001, 3'b001};
   localparam logic [2:0]  EXP_LOW [13] = '{3'b010, 3'b010, 3'b010, 3'b011, 3'b001,
      3'b001, 3'b001, 3'b101, 3'b100, 3'b100, 3'b100, 3'b110, 3'b110};

   always #2.5 clk = ~clk;

   tpd_gate_decoder #(.CLK_PERIOD_NS(5), .NUM_PHASES(3)) u0 (
      .clk(clk), .rst_n(rst_n), .in_hi(in_hi), .in_lo(in_lo), .in_mode(in_mode),
      .fw_diode(fw_diode), .dt_code(dt_code), .gate_off(gate_off),
      .gate_hi(gate_hi), .gate_lo(gate_lo)
   );

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk6(input string tag, input logic [2:0] eh, input logic [2:0] el);
      tests++;
      if (gate_hi !== eh || gate_lo !== el) begin
         fails++;
         $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", tag, gate_hi, gate_lo, eh, el);
      end
   endtask

   task automatic chk_int(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic set_code(input logic [3:0] c, input logic pwm);
      in_lo[0] = c[3]; in_hi[1] = c[2]; in_lo[1] = c[1]; in_hi[2] = c[0];
      in_hi[0] = pwm;
   endtask

   // R10
   task automatic t_reset();
      chk6("R10 reset state", 3'b000, 3'b000);
   endtask

   // R1
   task automatic t_six();
      dt_code = 3'd0;
      for (int m = 0; m < 2; m++) begin
         in_mode = (m == 0) ? 2'b00 : 2'b11;
         in_hi = 3'b011; in_lo = 3'b110; wait_n(25);
         chk6("R1 six-input mixed", 3'b001, 3'b100);
         in_hi = 3'b000; in_lo = 3'b000; wait_n(25);
         chk6("R1 six-input none", 3'b000, 3'b000);
         in_hi = 3'b010; in_lo = 3'b101; wait_n(25);
         chk6("R1 six-input alt", 3'b010, 3'b101);
      end
   endtask

   // R2
   task automatic t_three();
      in_mode = 2'b01; dt_code = 3'd0;
      in_hi = 3'b101; in_lo = 3'b000; wait_n(25);
      chk6("R2 three-input", 3'b101, 3'b010);
      in_lo = 3'b111; wait_n(25);
      chk6("R2 low inputs ignored", 3'b101, 3'b010);
      in_hi = 3'b010; in_lo = 3'b010; wait_n(25);
      chk6("R2 three-input swap", 3'b010, 3'b101);
   endtask

   // R3 R4
   task automatic t_single();
      in_mode = 2'b10; dt_code = 3'd0; fw_diode = 1'b0;
      for (int i = 0; i < 13; i++) begin
         in_lo[2] = i[0];
         set_code(CODES[i], 1'b1); wait_n(25);
         chk6("R4 commutation code, pwm high", EXP_PWM[i], EXP_LOW[i]);
      end
      for (int i = 0; i < 13; i += 3) begin
         fw_diode = 1'b0; set_code(CODES[i], 1'b0); wait_n(25);
         chk6("R3 active freewheel, pwm low", 3'b000, EXP_LOW[i] | EXP_PWM[i]);
         fw_diode = 1'b1; wait_n(25);
         chk6("R3 diode freewheel, pwm low", 3'b000, EXP_LOW[i]);
         set_code(CODES[i], 1'b1); wait_n(25);
         chk6("R3 diode freewheel, pwm high", EXP_PWM[i], EXP_LOW[i]);
      end
      fw_diode = 1'b0; set_code(4'b0101, 1'b1); in_lo[2] = 1'b0; wait_n(25);
      in_lo[2] = 1'b1; wait_n(3);
      chk6("R3 in_lo[2] ignored", 3'b101, 3'b010);
   endtask

   // R5
   task automatic t_stop();
      in_mode = 2'b10; fw_diode = 1'b0;
      set_code(4'b0000, 1'b1); wait_n(25);
      chk6("R5 stop 0000", 3'b000, 3'b000);
      set_code(4'b0001, 1'b1); wait_n(25);
      chk6("R5 stop 0001", 3'b000, 3'b000);
      set_code(4'b1111, 1'b0); wait_n(25);
      chk6("R5 stop 1111", 3'b000, 3'b000);
   endtask

   // R6 R8: count samples with both gates of phase A off after a swap
   task automatic t_dead(input logic [2:0] code);
      int n;
      int overlap;
      in_mode = 2'b00; dt_code = code; in_lo = 3'b000;
      in_hi = 3'b001; wait_n(DT_CYC[code] + 10);
      in_hi = 3'b000; in_lo = 3'b001;
      n = 0; overlap = 0;
      while (n < 3000) begin
         @(negedge clk);
         if (gate_hi[0] && gate_lo[0]) overlap++;
         if (gate_lo[0]) break;
         if (n == 0) chk_int("R7 outgoing gate off at first edge", int'(gate_hi[0]), 0);
         n++;
      end
      chk_int("R6 dead-time gap in cycles", n, int'(DT_CYC[code]));
      chk_int("R8 no overlap during swap", overlap, 0);
   endtask

   // R7
   task automatic t_fast();
      in_mode = 2'b00; dt_code = 3'd0; in_hi = 3'b000; in_lo = 3'b000; wait_n(20);
      in_hi = 3'b001; wait_n(1);
      chk6("R7 turn-on after one edge", 3'b001, 3'b000);
      in_hi = 3'b000; wait_n(1);
      chk6("R7 turn-off after one edge", 3'b000, 3'b000);
   endtask

   // R9
   task automatic t_disable();
      int n;
      in_mode = 2'b00; dt_code = 3'd1; in_hi = 3'b000; in_lo = 3'b111; wait_n(40);
      chk6("R9 before disable", 3'b000, 3'b111);
      gate_off = 1'b1; wait_n(1);
      chk6("R9 disable forces off", 3'b000, 3'b000);
      wait_n(5);
      gate_off = 1'b0;
      n = 0;
      while (n < 3000) begin
         @(negedge clk);
         if (gate_lo[0]) break;
         n++;
      end
      chk_int("R9 recount after release", n, int'(DT_CYC[1]) - 1);
   endtask

   initial begin : main
      wait_n(3);
      t_reset();
      rst_n = 1'b1;
      wait_n(2);
      t_reset();
      t_six();
      t_three();
      t_single();
      t_stop();
      t_dead(3'd0);
      t_dead(3'd1);
      t_dead(3'd3);
      t_dead(3'd7);
      t_fast();
      t_disable();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : watchdog
      #(150000 * 5);
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule